// File: doc/BRIEF.md
# Parallel Pipelined Radix-2 Fourier Transform Core

This block computes a forward complex discrete Fourier transform over a whole frame of N points in every clock cycle. All N complex samples enter together on two wide buses, one for real parts and one for imaginary parts, qualified by a single valid bit. The frame passes through log2(N) registered ranks of radix-2 decimation-in-time butterflies. After exactly log2(N) cycles, all N complex bins leave together with their own valid bit. A new frame may enter on every clock.

Each input component is an 8-bit integer. Inside the block it is widened to a 16-bit fixed-point word with 8 integer and 8 fraction bits. The twiddle factors are constants computed at elaboration. They carry 14 fraction bits. Each rank floors its complex products back to the data grid, and no rounding is applied anywhere. The block does not scale between ranks, so the caller keeps the sum of the input magnitudes inside the output range. A parameter chooses, at elaboration, whether the bins leave in natural or bit-reversed order. The required instance is N = 16, and the design is written generically for any power of two.

Top module: `pfft_core`

## Requirements
- R1: For every accepted frame, the output bins equal X[k] = sum over n of x[n]·e^(−j2πkn/N), to within (2^(log2N+1) + 4·log2N) LSB per component, when no intermediate value leaves the 16-bit range.
- R2: Input sample n is the 8-bit two's complement integer at bits [8n+7:8n] of `in_re` (real part) and `in_im` (imaginary part). Its internal value is that integer times 256.
- R3: Output bin position m is a 16-bit two's complement word at bits [16m+15:16m] of `out_re`/`out_im`, scaled by 2^8 (8 integer bits, 8 fraction bits).
- R4: `out_valid` is high in exactly the cycle that lies log2(N) cycles after a cycle in which `in_valid` was high, and is low otherwise. Frames on consecutive clocks are all processed.
- R5: With BITREV_OUT = 0, output position m carries X[m]. With BITREV_OUT = 1, it carries X[r], where r is m with its log2(N) index bits reversed.
- R6: In a cycle where `in_valid` is low, the input data is ignored. While `out_valid` is low, `out_re` and `out_im` keep the last frame delivered.
- R7: A synchronous active-high `rst` forces `out_valid` low and all output words to zero, starting at the next clock edge.
- R8: An accepted frame of all-zero samples gives exactly zero in every bin.
- R9: A frame whose only nonzero sample is at index 0 gives exactly that sample, times 256, in every bin, with no truncation error. This holds at full scale (−128 and +127).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the input buses as holding a frame to transform |
| in_re | input | N·8 | Real parts of the N input samples |
| in_im | input | N·8 | Imaginary parts of the N input samples |
| out_valid | output | 1 | Marks the output buses as holding a new transformed frame |
| out_re | output | N·16 | Real parts of the N result bins |
| out_im | output | N·16 | Imaginary parts of the N result bins |

## Verification
The bench applies a set of input frames, each of which shows up a different class of fault:
- A lone sample at index 0 and an all-zero frame must come out exactly. A slip in the input alignment, in the sign extension at full scale, or in a wiring permutation cannot hide in the tolerance.
- A lone sample at index 1 sweeps every twiddle factor across the bins and exposes a wrong constant or a wrong multiply sign.
- A constant frame lands in bin 0 only, an alternating-sign frame lands in bin N/2 only, and a complex tone lands in one chosen bin. These show whether butterfly pairs are crossed.
- Bursts of random frames on consecutive clocks, mixed with idle cycles that carry junk data, separate latency faults, lost back-to-back frames and data that leaks through while the input is not valid.
- A second instance set for bit-reversed order is checked against the same reference.

// File: rtl/pfft_pkg.sv
package pfft_pkg;

   localparam real PI_C = 3.14159265358979323846;

   // reverse the low 'bits' bits of v
   function automatic int bit_rev(input int v, input int bits);
      int r = 0;
      for (int b = 0; b < bits; b++) r = (r << 1) | ((v >> b) & 1);
      return r;
   endfunction

   // power series, used only at elaboration; argument stays in [0, pi)
   function automatic real series_cos(input real x);
      real term = 1.0;
      real acc  = 1.0;
      for (int n = 1; n < 16; n++) begin
         term = -term * x * x / real'((2*n-1) * (2*n));
         acc  = acc + term;
      end
      return acc;
   endfunction

   function automatic real series_sin(input real x);
      real term = x;
      real acc  = x;
      for (int n = 1; n < 16; n++) begin
         term = -term * x * x / real'((2*n) * (2*n+1));
         acc  = acc + term;
      end
      return acc;
   endfunction

   function automatic int round_fix(input real v, input int frac);
      real s = v * real'(1 << frac);
      if (s >= 0.0) return $rtoi(s + 0.5);
      else          return -$rtoi(0.5 - s);
   endfunction

   // W_N^k = cos(2*pi*k/N) - j*sin(2*pi*k/N)
   function automatic int tw_re(input int k, input int n, input int frac);
      return round_fix(series_cos(2.0 * PI_C * real'(k) / real'(n)), frac);
   endfunction

   function automatic int tw_im(input int k, input int n, input int frac);
      return -round_fix(series_sin(2.0 * PI_C * real'(k) / real'(n)), frac);
   endfunction

endpackage

// File: rtl/pfft_bfly.sv
// One radix-2 butterfly: x0 = a + b*w, x1 = a - b*w (combinational)
module pfft_bfly #(
   parameter int D_W     = 16,
   parameter int TW_W    = 16,
   parameter int TW_FRAC = 14
) (
   input  logic signed [D_W-1:0]  a_re,
   input  logic signed [D_W-1:0]  a_im,
   input  logic signed [D_W-1:0]  b_re,
   input  logic signed [D_W-1:0]  b_im,
   input  logic signed [TW_W-1:0] w_re,
   input  logic signed [TW_W-1:0] w_im,
   output logic signed [D_W-1:0]  x0_re,
   output logic signed [D_W-1:0]  x0_im,
   output logic signed [D_W-1:0]  x1_re,
   output logic signed [D_W-1:0]  x1_im
);
   localparam int P_W = D_W + TW_W + 1;

   logic signed [P_W-1:0] prod_re, prod_im;
   logic signed [D_W-1:0] t_re, t_im;

   // four real products, summed, then floored back to the data grid
   always_comb begin
      prod_re = P_W'(b_re) * P_W'(w_re) - P_W'(b_im) * P_W'(w_im);
      prod_im = P_W'(b_re) * P_W'(w_im) + P_W'(b_im) * P_W'(w_re);
      t_re    = D_W'(prod_re >>> TW_FRAC);
      t_im    = D_W'(prod_im >>> TW_FRAC);
      x0_re   = a_re + t_re;
      x0_im   = a_im + t_im;
      x1_re   = a_re - t_re;
      x1_im   = a_im - t_im;
   end
endmodule

// File: rtl/pfft_stage.sv
// One registered rank of N/2 butterflies with span 2^STAGE
module pfft_stage #(
   parameter int N       = 16,
   parameter int D_W     = 16,
   parameter int TW_W    = 16,
   parameter int TW_FRAC = 14,
   parameter int STAGE   = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_v,
   input  logic [N*D_W-1:0] in_re,
   input  logic [N*D_W-1:0] in_im,
   output logic             out_v,
   output logic [N*D_W-1:0] out_re,
   output logic [N*D_W-1:0] out_im
);
   localparam int SPAN   = 1 << STAGE;
   localparam int STRIDE = N / (2 * SPAN);

   logic [N*D_W-1:0] nx_re, nx_im;

   for (genvar b = 0; b < N/2; b++) begin : g_bf
      localparam int J   = b % SPAN;
      localparam int TOP = (b / SPAN) * 2 * SPAN + J;
      localparam int BOT = TOP + SPAN;
      localparam int WR  = pfft_pkg::tw_re(J * STRIDE, N, TW_FRAC);
      localparam int WI  = pfft_pkg::tw_im(J * STRIDE, N, TW_FRAC);

      pfft_bfly #(.D_W(D_W), .TW_W(TW_W), .TW_FRAC(TW_FRAC)) u_bf (
         .a_re  (in_re[TOP*D_W +: D_W]),
         .a_im  (in_im[TOP*D_W +: D_W]),
         .b_re  (in_re[BOT*D_W +: D_W]),
         .b_im  (in_im[BOT*D_W +: D_W]),
         .w_re  (TW_W'(WR)),
         .w_im  (TW_W'(WI)),
         .x0_re (nx_re[TOP*D_W +: D_W]),
         .x0_im (nx_im[TOP*D_W +: D_W]),
         .x1_re (nx_re[BOT*D_W +: D_W]),
         .x1_im (nx_im[BOT*D_W +: D_W])
      );
   end

   // data registers load only with a valid frame (R6)
   always_ff @(posedge clk) begin
      if (rst) begin
         out_v  <= 1'b0;
         out_re <= '0;
         out_im <= '0;
      end else begin
         out_v <= in_v;
         if (in_v) begin
            out_re <= nx_re;
            out_im <= nx_im;
         end
      end
   end
endmodule

// File: rtl/pfft_core.sv
// Fully parallel radix-2 DIT transform, log2(N) registered ranks
module pfft_core #(
   parameter int N          = 16,
   parameter int IN_W       = 8,
   parameter int D_W        = 16,
   parameter int FRAC       = 8,
   parameter int TW_W       = 16,
   parameter int TW_FRAC    = 14,
   parameter bit BITREV_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [N*IN_W-1:0] in_re,
   input  logic [N*IN_W-1:0] in_im,
   output logic              out_valid,
   output logic [N*D_W-1:0]  out_re,
   output logic [N*D_W-1:0]  out_im
);
   localparam int LOG_N = $clog2(N);

   initial begin
      assert (N >= 2 && (1 << LOG_N) == N)
         else $fatal(1, "pfft_core: N must be a power of two >= 2");
      assert (D_W >= IN_W + FRAC)
         else $fatal(1, "pfft_core: D_W too narrow for IN_W + FRAC");
      assert (TW_FRAC <= TW_W - 2)
         else $fatal(1, "pfft_core: TW_W cannot hold +1.0 at TW_FRAC");
   end

   logic [N*D_W-1:0] lane_re [LOG_N+1];
   logic [N*D_W-1:0] lane_im [LOG_N+1];
   logic             lane_v  [LOG_N+1];

   // R2: bit-reversed gather, sign extension, integer part aligned above FRAC
   for (genvar n = 0; n < N; n++) begin : g_in
      localparam int SRC = pfft_pkg::bit_rev(n, LOG_N);
      assign lane_re[0][n*D_W +: D_W] =
         D_W'($signed({in_re[SRC*IN_W +: IN_W], {FRAC{1'b0}}}));
      assign lane_im[0][n*D_W +: D_W] =
         D_W'($signed({in_im[SRC*IN_W +: IN_W], {FRAC{1'b0}}}));
   end
   assign lane_v[0] = in_valid;

   for (genvar s = 0; s < LOG_N; s++) begin : g_stage
      pfft_stage #(
         .N(N), .D_W(D_W), .TW_W(TW_W), .TW_FRAC(TW_FRAC), .STAGE(s)
      ) u_st (
         .clk    (clk),
         .rst    (rst),
         .in_v   (lane_v[s]),
         .in_re  (lane_re[s]),
         .in_im  (lane_im[s]),
         .out_v  (lane_v[s+1]),
         .out_re (lane_re[s+1]),
         .out_im (lane_im[s+1])
      );
   end

   // R5: output order chosen at elaboration
   if (BITREV_OUT) begin : g_rev
      for (genvar m = 0; m < N; m++) begin : g_lane
         localparam int SRC = pfft_pkg::bit_rev(m, LOG_N);
         assign out_re[m*D_W +: D_W] = lane_re[LOG_N][SRC*D_W +: D_W];
         assign out_im[m*D_W +: D_W] = lane_im[LOG_N][SRC*D_W +: D_W];
      end
   end else begin : g_nat
      assign out_re = lane_re[LOG_N];
      assign out_im = lane_im[LOG_N];
   end

   assign out_valid = lane_v[LOG_N];
endmodule

// File: rtl/pfft_chk.sv
module pfft_chk #(
   parameter int N    = 16,
   parameter int IN_W = 8,
   parameter int D_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [N*IN_W-1:0] in_re,
   input logic [N*IN_W-1:0] in_im,
   input logic              out_valid,
   input logic [N*D_W-1:0]  out_re,
   input logic [N*D_W-1:0]  out_im
);
   localparam int LOG_N = $clog2(N);

   logic [LOG_N-1:0] v_hist, z_hist;
   logic             rst_d;
   logic             zero_in;

   assign zero_in = in_valid && (in_re == '0) && (in_im == '0);

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst) begin
         v_hist <= '0;
         z_hist <= '0;
      end else begin
         v_hist <= LOG_N'({v_hist, in_valid});
         z_hist <= LOG_N'({z_hist, zero_in});
      end
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_hist[LOG_N-1]) else $error("valid latency broken"); // R4

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_re) && $stable(out_im))) else $error("output moved while idle"); // R6

   AST_ZERO_FRAME: assert property (@(posedge clk) disable iff (rst)
      z_hist[LOG_N-1] |-> (out_re == '0 && out_im == '0)) else $error("zero frame not zero"); // R8

   always @(posedge clk) begin
      if (rst_d === 1'b1) begin
         AST_RESET_CLEAR: assert (!out_valid && out_re == '0 && out_im == '0)
            else $error("reset did not clear outputs"); // R7
      end
   end
endmodule

bind pfft_core pfft_chk #(.N(N), .IN_W(IN_W), .D_W(D_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_re     (in_re),
   .in_im     (in_im),
   .out_valid (out_valid),
   .out_re    (out_re),
   .out_im    (out_im)
);

// File: tb/pfft_core_test.sv
module pfft_core_test;
   localparam int  N     = 16;
   localparam int  L     = 4;
   localparam int  IN_W  = 8;
   localparam int  D_W   = 16;
   localparam real TOL   = real'((1 << (L+1)) + 4*L);
   localparam real EXACT = 0.001;
   localparam real PI_B  = 3.14159265358979323846;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [N*IN_W-1:0] in_re = '0, in_im = '0;
   logic v_nat, v_rev;
   logic [N*D_W-1:0] re_nat, im_nat, re_rev, im_rev;

   pfft_core #(.N(N)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .out_valid(v_nat), .out_re(re_nat), .out_im(im_nat));

   pfft_core #(.N(N), .BITREV_OUT(1'b1)) uut_rev (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .out_valid(v_rev), .out_re(re_rev), .out_im(im_rev));

   always #2 clk = ~clk;

   int    n_cmp = 0, n_bad = 0;
   bit    done = 1'b0;
   real   q_re[$], q_im[$], q_tol[$];
   string q_tag[$];
   bit    hist[$];
   int    xr[N], xi[N];
   int    last_nr[N], last_ni[N], last_rr[N], last_ri[N];

   function automatic int brev(input int v);
      int r = 0;
      for (int b = 0; b < L; b++) r = (r << 1) | ((v >> b) & 1);
      return r;
   endfunction

   function automatic int sval(input logic [N*D_W-1:0] bus, input int m);
      return int'($signed(bus[m*D_W +: D_W]));
   endfunction

   task automatic cmp(input int act, input real exp, input real tol,
                      input string tag, input string which, input int pos);
      real d;
      n_cmp++;
      d = real'(act) - exp;
      if (d < 0.0) d = -d;
      if (d > tol) begin
         n_bad++;
         $display("FAIL %s %s pos %0d: actual %0d expected %0.3f (tol %0.3f)",
                  tag, which, pos, act, exp, tol);
      end
   endtask

   task automatic check_cycle();
      bit    ev;
      real   er[N], ei[N];
      real   tol;
      string tag;
      bit    held;
      ev = hist.pop_front();
      n_cmp++;
      if (v_nat !== ev || v_rev !== ev) begin
         n_bad++;
         $display("FAIL R4 out_valid nat=%0b rev=%0b expected %0b", v_nat, v_rev, ev);
      end
      if (ev) begin
         for (int m = 0; m < N; m++) begin
            er[m] = q_re.pop_front();
            ei[m] = q_im.pop_front();
         end
         tol = q_tol.pop_front();
         tag = q_tag.pop_front();
         for (int m = 0; m < N; m++) begin
            cmp(sval(re_nat, m), er[m], tol, tag, "natural re", m);
            cmp(sval(im_nat, m), ei[m], tol, tag, "natural im", m);
            cmp(sval(re_rev, m), er[brev(m)], tol, {tag, " R5"}, "bitrev re", m);
            cmp(sval(im_rev, m), ei[brev(m)], tol, {tag, " R5"}, "bitrev im", m);
            last_nr[m] = sval(re_nat, m);
            last_ni[m] = sval(im_nat, m);
            last_rr[m] = sval(re_rev, m);
            last_ri[m] = sval(im_rev, m);
         end
      end else begin
         held = 1'b1;
         for (int m = 0; m < N; m++) begin
            if (sval(re_nat, m) != last_nr[m] || sval(im_nat, m) != last_ni[m] ||
                sval(re_rev, m) != last_rr[m] || sval(im_rev, m) != last_ri[m])
               held = 1'b0;
         end
         n_cmp++;
         if (!held) begin
            n_bad++;
            $display("FAIL R6 idle output changed: bin0 actual %0d expected %0d",
                     sval(re_nat, 0), last_nr[0]);
         end
      end
   endtask

   // drive xr/xi for one cycle; v selects whether it is a frame
   task automatic apply(input bit v, input real tol, input string tag);
      real ar, ai, th;
      @(negedge clk);
      check_cycle();
      for (int n = 0; n < N; n++) begin
         in_re[n*IN_W +: IN_W] = IN_W'(xr[n]);
         in_im[n*IN_W +: IN_W] = IN_W'(xi[n]);
      end
      in_valid = v;
      hist.push_back(v);
      if (v) begin
         for (int k = 0; k < N; k++) begin
            ar = 0.0;
            ai = 0.0;
            for (int n = 0; n < N; n++) begin
               th = 2.0 * PI_B * real'(k * n) / real'(N);
               ar = ar + real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
               ai = ai + real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
            end
            q_re.push_back(ar * 256.0);
            q_im.push_back(ai * 256.0);
         end
         q_tol.push_back(tol);
         q_tag.push_back(tag);
      end
   endtask

   task automatic fill(input int vr, input int vi);
      for (int n = 0; n < N; n++) begin
         xr[n] = vr;
         xi[n] = vi;
      end
   endtask

   task automatic fill_rand();
      for (int n = 0; n < N; n++) begin
         xr[n] = int'($urandom_range(6, 0)) - 3;
         xi[n] = int'($urandom_range(6, 0)) - 3;
      end
   endtask

   task automatic idle_junk();
      for (int n = 0; n < N; n++) begin
         xr[n] = int'($urandom_range(255, 0)) - 128;
         xi[n] = int'($urandom_range(255, 0)) - 128;
      end
      apply(1'b0, 0.0, "");
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      n_cmp++;
      if (v_nat !== 1'b0 || v_rev !== 1'b0 || re_nat !== '0 || im_nat !== '0 ||
          re_rev !== '0 || im_rev !== '0) begin
         n_bad++;
         $display("FAIL R7 reset state: valid %0b re0 %0d expected 0 / 0", v_nat, sval(re_nat, 0));
      end
      for (int m = 0; m < N; m++) begin
         last_nr[m] = 0; last_ni[m] = 0; last_rr[m] = 0; last_ri[m] = 0;
      end
      rst = 1'b0;
      for (int i = 0; i < L; i++) hist.push_back(1'b0);

      // R9 / R2 / R3: full-scale impulse at index 0, exact
      fill(0, 0); xr[0] = -128; xi[0] = 127;
      apply(1'b1, EXACT, "R9 R2 R3 impulse0");
      idle_junk();
      // R8: zero frame, exact
      fill(0, 0);
      apply(1'b1, EXACT, "R8 zero");
      // R1: constant, impulse at 1, alternating, tone
      fill(2, 1);
      apply(1'b1, TOL, "R1 constant");
      fill(0, 0); xr[1] = 3; xi[1] = -1;
      apply(1'b1, TOL, "R1 impulse1");
      for (int n = 0; n < N; n++) begin
         xr[n] = (n % 2 == 0) ? 3 : -3;
         xi[n] = (n % 2 == 0) ? -2 : 2;
      end
      apply(1'b1, TOL, "R1 alternating");
      for (int n = 0; n < N; n++) begin
         xr[n] = int'(3.0 * $cos(2.0 * PI_B * 3.0 * real'(n) / real'(N)));
         xi[n] = int'(3.0 * $sin(2.0 * PI_B * 3.0 * real'(n) / real'(N)));
      end
      apply(1'b1, TOL, "R1 tone3");
      // R4: back-to-back random frames
      for (int f = 0; f < 20; f++) begin
         fill_rand();
         apply(1'b1, TOL, "R4 R1 burst");
      end
      // R6: junk with valid low, then sparse frames
      repeat (6) idle_junk();
      for (int f = 0; f < 12; f++) begin
         fill_rand();
         apply(1'b1, TOL, "R6 R1 sparse");
         repeat (f % 3) idle_junk();
      end
      fill(-3, -3);
      apply(1'b1, TOL, "R1 negative constant");
      repeat (L + 3) idle_junk();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R4 watchdog: run still active after %0d cycles, expected end", 200000);
         summary();
         $finish;
      end
   end
endmodule